// File: doc/BRIEF.md
# Power-Fail Chip-Enable Guard

This controller sits between a host and a battery-backed memory with a small set of timekeeping registers. It watches a supply-fail flag from an analog comparator. When the supply is good, the host's active-low chip enable passes to the memory one clock later. When the supply fails, the controller overrides that enable according to a mode pin. In RAM mode the enable is held inactive so the memory cannot be written. In ROM mode the enable is forced active, because a ROM needs no write protection. While the fault lasts, the controller also steers the backup supply to the better of two batteries.

The raw fail flag passes through a synchronizer chain and then a stability filter. A change is accepted only after it has persisted for a programmable number of clocks. Entering the fault state fires a one-clock abort strobe and raises a lockout. The abort throws away any half-finished serial register write. The lockout then refuses all register traffic until the filtered supply is good again. The internal register is written one bit at a time and commits only when a full word has arrived. An abort therefore never leaves it partly changed.

Top module: `pfail_ce_guard`

## Requirements
- R1: After a synchronous active-low reset: `mem_ce_n` = 1, `lockout` = 0, `abort_stb` = 0, `bat_sel` = 0 (battery one) and `reg_q` = 0.
- R2: While the filtered state is power-good, `mem_ce_n` equals the value `host_ce_n` had at the previous clock edge.
- R3: In RAM mode (`rom_mode` = 0), `mem_ce_n` is 1 from the clock after `lockout` rises until the clock after it falls.
- R4: In ROM mode (`rom_mode` = 1), `mem_ce_n` is 0 over the same fault window.
- R5: `supply_fail` passes through SYNC_STAGES flops. The filtered state changes only after the synchronized level has differed from it for STABLE_CYC consecutive clocks. A pulse shorter than STABLE_CYC clocks never changes `lockout`.
- R6: `abort_stb` is high for exactly one clock, in the first clock in which `lockout` is high.
- R7: A fault discards the bits of a partly received word. `reg_q` keeps its last committed value, and the next word starts from bit 0.
- R8: While `lockout` is high, `wr_stb` is ignored and `reg_q` does not change.
- R9: `lockout` falls only after the synchronized fail flag has been low for STABLE_CYC consecutive clocks.
- R10: During a fault, `bat_sel` chooses battery one (0) if `bat2_ok` = 0. Otherwise it chooses battery two (1) if `bat1_ok` = 0. Otherwise it follows `bat2_higher`. Each choice takes effect one clock later. While power is good, `bat_sel` holds its value.
- R11: Each `wr_stb` pulse shifts in `wr_bit`, least significant bit first. After DATA_W pulses, the word loads into `reg_q` on the clock of the last pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_ce_n | input | 1 | Host chip enable, active low |
| supply_fail | input | 1 | Asynchronous comparator flag, 1 = supply below threshold |
| rom_mode | input | 1 | 0 = RAM mode, 1 = ROM mode |
| bat1_ok | input | 1 | Battery one present |
| bat2_ok | input | 1 | Battery two present |
| bat2_higher | input | 1 | Comparator: battery two above battery one |
| wr_stb | input | 1 | Serial register write strobe |
| wr_bit | input | 1 | Serial register write data |
| mem_ce_n | output | 1 | Gated chip enable to memory, active low |
| bat_sel | output | 1 | Backup source, 0 = battery one, 1 = battery two |
| abort_stb | output | 1 | One-clock pulse on fault entry |
| lockout | output | 1 | Register access refused |
| reg_q | output | DATA_W | Committed register contents |

## Verification
A filter counter that drifts by even one clock moves the `lockout` edge. The forced `mem_ce_n` level then moves as well, one clock after it, and the per-clock comparison catches this at once. A bit counter that survives an abort lets the next full word commit early or misaligned. `reg_q` shows this as soon as the next word completes. A battery choice that ignores the presence flags shows up on `bat_sel` one clock after the comparator inputs change.

// File: rtl/pfail_guard_pkg.sv
package pfail_guard_pkg;
   typedef enum logic {
      BAT_ONE = 1'b0,
      BAT_TWO = 1'b1
   } bat_e;

   function automatic bat_e pick_bat(input logic ok1, input logic ok2, input logic two_hi);
      if (!ok2)      return BAT_ONE;
      else if (!ok1) return BAT_TWO;
      else           return two_hi ? BAT_TWO : BAT_ONE;
   endfunction
endpackage

// File: rtl/pfail_filter.sv
module pfail_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int STABLE_CYC  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_fail,
   output logic fault,
   output logic enter
);
   localparam int CW = $clog2(STABLE_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (STABLE_CYC < 1) begin : g_bad_stable
      $error("STABLE_CYC must be at least 1");
   end

   logic [SYNC_STAGES-1:0] chain;
   logic                   lvl;
   logic [CW-1:0]          cnt;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= raw_fail;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign lvl   = chain[SYNC_STAGES-1];
   assign enter = lvl && !fault && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault <= 1'b0;
         cnt   <= '0;
      end else if (lvl == fault) begin
         cnt <= '0;
      end else if (cnt == LAST) begin
         fault <= lvl;
         cnt   <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R5 / R9: the filtered state only ever moves toward the synchronized level
   p_moves_to_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fault) |-> fault == $past(lvl));
endmodule

// File: rtl/pfail_ce_gate.sv
module pfail_ce_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic fault,
   input  logic rom_mode,
   input  logic host_ce_n,
   output logic mem_ce_n
);
   always_ff @(posedge clk) begin
      if (!rst_n)     mem_ce_n <= 1'b1;
      else if (fault) mem_ce_n <= !rom_mode;
      else            mem_ce_n <= host_ce_n;
   end

   p_ce_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !fault |=> mem_ce_n == $past(host_ce_n));
   p_ram_protect_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && !rom_mode) |=> mem_ce_n);
   p_rom_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && rom_mode) |=> !mem_ce_n);
endmodule

// File: rtl/pfail_bat_sel.sv
module pfail_bat_sel
   import pfail_guard_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic fault,
   input  logic bat1_ok,
   input  logic bat2_ok,
   input  logic bat2_higher,
   output logic bat_sel
);
   bat_e sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     sel_q <= BAT_ONE;
      else if (fault) sel_q <= pick_bat(bat1_ok, bat2_ok, bat2_higher);
   end

   assign bat_sel = sel_q;

   p_absent_two_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && !bat2_ok) |=> !bat_sel);
   p_absent_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && bat2_ok && !bat1_ok) |=> bat_sel);
   p_hold_good_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !fault |=> $stable(bat_sel));
endmodule

// File: rtl/pfail_xfer.sv
module pfail_xfer #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fault,
   input  logic              enter,
   input  logic              wr_stb,
   input  logic              wr_bit,
   output logic [DATA_W-1:0] reg_q
);
   localparam int BW = $clog2(DATA_W + 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] sh;
   logic [BW-1:0]     nbits;
   logic [DATA_W-1:0] next_sh;

   assign next_sh = {wr_bit, sh[DATA_W-1:1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh    <= '0;
         nbits <= '0;
         reg_q <= '0;
      end else if (enter) begin
         sh    <= '0;
         nbits <= '0;
      end else if (!fault && wr_stb) begin
         sh <= next_sh;
         if (nbits == LAST_BIT) begin
            reg_q <= next_sh;
            nbits <= '0;
         end else begin
            nbits <= nbits + 1'b1;
         end
      end
   end

   p_locked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> $stable(reg_q));
   p_abort_no_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      enter |=> $stable(reg_q));
   p_abort_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      enter |=> nbits == '0);
endmodule

// File: rtl/pfail_ce_guard.sv
module pfail_ce_guard #(
   parameter int SYNC_STAGES = 2,
   parameter int STABLE_CYC  = 4,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_ce_n,
   input  logic              supply_fail,
   input  logic              rom_mode,
   input  logic              bat1_ok,
   input  logic              bat2_ok,
   input  logic              bat2_higher,
   input  logic              wr_stb,
   input  logic              wr_bit,
   output logic              mem_ce_n,
   output logic              bat_sel,
   output logic              abort_stb,
   output logic              lockout,
   output logic [DATA_W-1:0] reg_q
);
   logic fault;
   logic enter;

   pfail_filter #(.SYNC_STAGES(SYNC_STAGES), .STABLE_CYC(STABLE_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_fail(supply_fail),
      .fault(fault), .enter(enter));

   pfail_ce_gate u_ce (
      .clk(clk), .rst_n(rst_n), .fault(fault), .rom_mode(rom_mode),
      .host_ce_n(host_ce_n), .mem_ce_n(mem_ce_n));

   pfail_bat_sel u_bat (
      .clk(clk), .rst_n(rst_n), .fault(fault), .bat1_ok(bat1_ok),
      .bat2_ok(bat2_ok), .bat2_higher(bat2_higher), .bat_sel(bat_sel));

   pfail_xfer #(.DATA_W(DATA_W)) u_xfer (
      .clk(clk), .rst_n(rst_n), .fault(fault), .enter(enter),
      .wr_stb(wr_stb), .wr_bit(wr_bit), .reg_q(reg_q));

   always_ff @(posedge clk) begin
      if (!rst_n) abort_stb <= 1'b0;
      else        abort_stb <= enter;
   end

   assign lockout = fault;

   p_abort_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      abort_stb |=> !abort_stb);
   p_abort_on_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lockout) |-> abort_stb);
   p_abort_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      abort_stb |-> lockout);
endmodule

// File: tb/pfail_ce_guard_tb.sv
module pfail_ce_guard_tb_top;
   localparam int SYNC = 2;
   localparam int STAB = 4;
   localparam int W    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_ce_n = 1'b1, supply_fail = 1'b0, rom_mode = 1'b0;
   logic bat1_ok = 1'b1, bat2_ok = 1'b1, bat2_higher = 1'b0;
   logic wr_stb = 1'b0, wr_bit = 1'b0;
   logic mem_ce_n, bat_sel, abort_stb, lockout;
   logic [W-1:0] reg_q;

   always #2 clk = ~clk;

   pfail_ce_guard #(.SYNC_STAGES(SYNC), .STABLE_CYC(STAB), .DATA_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_ce_n(host_ce_n), .supply_fail(supply_fail),
      .rom_mode(rom_mode), .bat1_ok(bat1_ok), .bat2_ok(bat2_ok),
      .bat2_higher(bat2_higher), .wr_stb(wr_stb), .wr_bit(wr_bit),
      .mem_ce_n(mem_ce_n), .bat_sel(bat_sel), .abort_stb(abort_stb),
      .lockout(lockout), .reg_q(reg_q));

   int n_chk = 0, n_fail = 0, cycles = 0;
   bit started = 0;

   // reference model state
   bit     m_pipe[$];
   bit     m_fault, m_ce, m_bat, m_abort;
   int     m_run, m_bits;
   int     m_acc, m_reg;
   string  m_ce_req;

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      started <= 1'b1;
      if (!rst_n) begin
         m_pipe = {};
         for (int i = 0; i < SYNC; i++) m_pipe.push_back(1'b0);
         m_fault = 0; m_ce = 1; m_bat = 0; m_abort = 0;
         m_run = 0; m_bits = 0; m_acc = 0; m_reg = 0; m_ce_req = "R1";
      end else begin
         bit old_fault;
         bit lvl;
         bit ent;
         old_fault = m_fault;
         lvl = m_pipe.pop_front();
         m_pipe.push_back(supply_fail);
         ent = 0;
         if (lvl == m_fault) m_run = 0;
         else begin
            m_run++;
            if (m_run >= STAB) begin
               m_fault = lvl; m_run = 0; ent = lvl;
            end
         end
         m_abort = ent;
         if (old_fault) begin
            m_ce = !rom_mode;
            m_ce_req = rom_mode ? "R4" : "R3";
            if (!bat2_ok) m_bat = 0;
            else if (!bat1_ok) m_bat = 1;
            else m_bat = bat2_higher;
         end else begin
            m_ce = host_ce_n;
            m_ce_req = "R2";
         end
         if (ent) begin
            m_bits = 0; m_acc = 0;
         end else if (!old_fault && wr_stb) begin
            if (wr_bit) m_acc = m_acc | (1 << m_bits);
            m_bits++;
            if (m_bits == W) begin
               m_reg = m_acc; m_acc = 0; m_bits = 0;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (started) begin
         chk(m_ce_req, "mem_ce_n", int'(mem_ce_n), int'(m_ce));
         chk("R10", "bat_sel", int'(bat_sel), int'(m_bat));
         chk("R6", "abort_stb", int'(abort_stb), int'(m_abort));
         chk("R5", "lockout", int'(lockout), int'(m_fault));
         chk("R11", "reg_q", int'(reg_q), m_reg);
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(bit b);
      @(negedge clk);
      wr_stb = 1'b1; wr_bit = b;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic send_word(int v);
      for (int i = 0; i < W; i++) send_bit(v[i]);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            finish_run();
         end
      end
   end

   initial begin
      step(3);
      // R1 reset values
      chk("R1", "mem_ce_n", int'(mem_ce_n), 1);
      chk("R1", "lockout", int'(lockout), 0);
      chk("R1", "abort_stb", int'(abort_stb), 0);
      chk("R1", "bat_sel", int'(bat_sel), 0);
      chk("R1", "reg_q", int'(reg_q), 0);
      rst_n = 1'b1;

      // R2 chip enable follows host with one clock delay
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         host_ce_n = ((i * 7) % 3) == 0;
      end

      // R11 full word, LSB first
      send_word(8'hA5);
      step(1);
      chk("R11", "word commit", int'(reg_q), 8'hA5);

      // R5 short glitch ignored
      @(negedge clk); supply_fail = 1'b1;
      step(STAB - 1);
      supply_fail = 1'b0;
      step(10);
      chk("R5", "glitch lockout", int'(lockout), 0);

      // R10 comparator changes while good are ignored
      bat2_higher = 1'b1;
      step(3);
      chk("R10", "hold while good", int'(bat_sel), 0);

      // R7 partial word then fault in RAM mode
      send_bit(1); send_bit(1); send_bit(0);
      host_ce_n = 1'b0;
      @(negedge clk); supply_fail = 1'b1;
      step(SYNC + STAB + 3);
      chk("R3", "ram ce forced", int'(mem_ce_n), 1);
      chk("R7", "no partial commit", int'(reg_q), 8'hA5);
      // R8 strobes ignored under lockout
      send_word(8'hFF);
      chk("R8", "locked reg_q", int'(reg_q), 8'hA5);
      // R10 battery choices
      bat2_higher = 1'b1; step(2);
      chk("R10", "higher two", int'(bat_sel), 1);
      bat2_ok = 1'b0; step(2);
      chk("R10", "two absent", int'(bat_sel), 0);
      bat2_ok = 1'b1; bat1_ok = 1'b0; bat2_higher = 1'b0; step(2);
      chk("R10", "one absent", int'(bat_sel), 1);
      bat1_ok = 1'b1; step(2);
      chk("R10", "higher one", int'(bat_sel), 0);

      // R9 recovery after filtered good level
      @(negedge clk); supply_fail = 1'b0;
      step(SYNC + STAB - 1);
      chk("R9", "still locked", int'(lockout), 1);
      step(4);
      chk("R9", "released", int'(lockout), 0);

      // R7 next word starts at bit 0
      send_word(8'h3C);
      step(1);
      chk("R7", "fresh word", int'(reg_q), 8'h3C);

      // R4 ROM mode fault
      rom_mode = 1'b1; host_ce_n = 1'b1;
      @(negedge clk); supply_fail = 1'b1;
      step(SYNC + STAB + 3);
      chk("R4", "rom ce forced", int'(mem_ce_n), 0);
      @(negedge clk); supply_fail = 1'b0;
      step(SYNC + STAB + 4);
      chk("R2", "ce restored", int'(mem_ce_n), 1);

      // R6 second RAM fault, abort once
      rom_mode = 1'b0;
      @(negedge clk); supply_fail = 1'b1;
      step(SYNC + STAB + 4);
      @(negedge clk); supply_fail = 1'b0;
      step(SYNC + STAB + 4);
      finish_run();
   end
endmodule